// File: doc/BRIEF.md
# Command-Sequence Write Guard

This block sits between the host write port of a byte-wide non-volatile memory and its page write controller. It decides three things for the controller. The first is whether each incoming byte belongs to a fixed unlock or protection command, in which case the byte must not be stored. The second is whether the page collected in the current load may be committed to the array. The third is the current protection state.

The protection flag is persistent. Only a dedicated factory-clear input resets it; the ordinary reset leaves it unchanged. A command only changes the flag when the write period that follows the load finishes. The page controller signals that moment with a programming-done pulse.

A load opens with the first accepted strobe. It closes when no strobe arrives for a set number of idle cycles. From then until the programming-done pulse, strobes are ignored. Commands are recognised only as the first bytes of a load. Once a byte fails to match, the rest of that load is plain data.

Top module: `cmdseq_guard`

## Requirements
- R1: After the factory clear (prot_rst_ni low), prot_o is 0, commit_ok_o is 1 and cmd_byte_o is 0 while no strobe is present.
- R2: The arm command is three strobes at the start of a load: data 8'hAA to address 15'h5555, then 8'h55 to 15'h2AAA, then 8'hA0 to 15'h5555. cmd_byte_o is 1 in the same cycle as each of these strobes, and 0 for data bytes that follow.
- R3: After an arm command, prot_o goes to 1 in the cycle after the prog_done_i pulse, and not before. This holds even if no data byte followed the command.
- R4: The disarm command is six strobes: 8'hAA@15'h5555, 8'h55@15'h2AAA, 8'h80@15'h5555, 8'hAA@15'h5555, 8'h55@15'h2AAA, 8'h20@15'h5555. All six are flagged, and prot_o clears only after the prog_done_i pulse.
- R5: While prot_o is 1, a load that does not begin with a command gives commit_ok_o = 0. prot_o stays 1. While prot_o is 0, commit_ok_o is 1.
- R6: While prot_o is 1, a load that begins with the arm command raises commit_ok_o after the third command byte. prot_o remains 1 after the write period.
- R7: A strobe whose address or data differs from the expected next command byte is not flagged. No later strobe of the same load is flagged, and the protection state does not change.
- R8: A load closes after BLC_CYC consecutive cycles without a strobe. Strobes after that, until prog_done_i, are ignored: they are not flagged and they unlock nothing.
- R9: rst_ni does not change prot_o.
- R10: The unlock from a command lasts only until the prog_done_i pulse. After the pulse, commit_ok_o equals the inverse of prot_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; clears the matcher, load tracking and pending state |
| prot_rst_ni | input | 1 | Active-low asynchronous factory clear of the persistent protection flag |
| wr_i | input | 1 | Write strobe, one byte per cycle when high |
| addr_i | input | 15 | Byte address of the strobe |
| data_i | input | 8 | Byte data of the strobe |
| prog_done_i | input | 1 | One-cycle pulse at the end of the internal write period |
| prot_o | output | 1 | Persistent protection state |
| commit_ok_o | output | 1 | High when the collected page may be stored |
| cmd_byte_o | output | 1 | High in the same cycle as a strobe that is a command byte |

## Verification
The hardest situation to reach is a strobe that arrives after a load has closed but before the write period ends. In that window the byte must be ignored, even when it is a valid command. The bench reaches it in two ways. It opens a load and then idles longer than the gap limit without pulsing prog_done_i, then sends a complete arm command and checks that nothing is flagged or unlocked. It also breaks a command in the middle of its sequence with a long gap. A second case is protection surviving the ordinary reset. The bench pulses rst_ni while protected and checks prot_o before and after the factory clear.

// File: rtl/cmdseq_guard_pkg.sv
`timescale 1ns/1ps
package cmdseq_guard_pkg;
  localparam int ADDR_W = 15;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] KEY_ADDR_A = 15'h5555;
  localparam logic [ADDR_W-1:0] KEY_ADDR_B = 15'h2AAA;
  localparam logic [DATA_W-1:0] KEY_OPEN   = 8'hAA;
  localparam logic [DATA_W-1:0] KEY_CONF   = 8'h55;
  localparam logic [DATA_W-1:0] KEY_ARM    = 8'hA0;
  localparam logic [DATA_W-1:0] KEY_EXT    = 8'h80;
  localparam logic [DATA_W-1:0] KEY_DISARM = 8'h20;

  localparam int SEQ_LEN = 6;
  localparam int STEP_W  = $clog2(SEQ_LEN);
  localparam int ARM_STEP = 2;

  typedef enum logic [1:0] {PH_IDLE, PH_LOAD, PH_PROG} phase_e;
  typedef enum logic [1:0] {PEND_NONE, PEND_SET, PEND_CLR} pend_e;
endpackage

// File: rtl/cmdseq_load_track.sv
`timescale 1ns/1ps
module cmdseq_load_track
  import cmdseq_guard_pkg::*;
#(
  parameter int BLC_CYC = 16
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   wr_i,
  input  logic   done_i,
  output phase_e phase_o,
  output logic   take_o
);
  localparam int CW = $clog2(BLC_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(BLC_CYC - 1);

  phase_e        ph_q;
  logic [CW-1:0] gap_q;

  // strobes are accepted outside the programming window; done wins
  assign take_o  = wr_i && !done_i && (ph_q != PH_PROG);
  assign phase_o = ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      gap_q <= '0;
    end else if (done_i) begin
      ph_q  <= PH_IDLE;
      gap_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (wr_i) begin
          ph_q  <= PH_LOAD;
          gap_q <= '0;
        end
        PH_LOAD: begin
          if (wr_i)              gap_q <= '0;
          else if (gap_q == LAST) ph_q  <= PH_PROG;
          else                    gap_q <= gap_q + 1'b1;
        end
        default: ph_q <= PH_PROG;
      endcase
    end
  end
endmodule

// File: rtl/cmdseq_matcher.sv
`timescale 1ns/1ps
module cmdseq_matcher
  import cmdseq_guard_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic          take_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          hit_o,
  output logic          arm_o,
  output logic          disarm_o
);
  logic [STEP_W-1:0] step_q;
  logic              dead_q;
  logic [AW-1:0]     exp_a;
  logic [DW-1:0]     exp_d;
  logic              alt_ok;

  always_comb begin
    exp_a  = KEY_ADDR_A;
    exp_d  = KEY_OPEN;
    alt_ok = 1'b0;
    unique case (step_q)
      STEP_W'(0): begin exp_a = KEY_ADDR_A; exp_d = KEY_OPEN; end
      STEP_W'(1): begin exp_a = KEY_ADDR_B; exp_d = KEY_CONF; end
      STEP_W'(2): begin
        exp_a  = KEY_ADDR_A;
        exp_d  = KEY_ARM;
        alt_ok = (data_i == KEY_EXT);
      end
      STEP_W'(3): begin exp_a = KEY_ADDR_A; exp_d = KEY_OPEN; end
      STEP_W'(4): begin exp_a = KEY_ADDR_B; exp_d = KEY_CONF; end
      default:    begin exp_a = KEY_ADDR_A; exp_d = KEY_DISARM; end
    endcase
  end

  assign hit_o    = take_i && !dead_q && (addr_i == exp_a) &&
                    ((data_i == exp_d) || alt_ok);
  assign arm_o    = hit_o && (step_q == STEP_W'(ARM_STEP)) && (data_i == KEY_ARM);
  assign disarm_o = hit_o && (step_q == STEP_W'(SEQ_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      dead_q <= 1'b0;
    end else if (restart_i) begin
      step_q <= '0;
      dead_q <= 1'b0;
    end else if (take_i && !dead_q) begin
      // a finished or broken command turns the rest of the load into data
      if (!hit_o || arm_o || disarm_o) dead_q <= 1'b1;
      else                             step_q <= step_q + 1'b1;
    end
  end
endmodule

// File: rtl/cmdseq_prot_state.sv
`timescale 1ns/1ps
module cmdseq_prot_state
  import cmdseq_guard_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic prot_rst_ni,
  input  logic done_i,
  input  logic arm_i,
  input  logic disarm_i,
  output logic prot_o,
  output logic commit_ok_o
);
  logic  prot_q;
  logic  unlock_q;
  pend_e pend_q;

  // persistent flag: untouched by the ordinary reset
  always_ff @(posedge clk_i or negedge prot_rst_ni) begin
    if (!prot_rst_ni)                      prot_q <= 1'b0;
    else if (done_i && pend_q == PEND_SET) prot_q <= 1'b1;
    else if (done_i && pend_q == PEND_CLR) prot_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= PEND_NONE;
      unlock_q <= 1'b0;
    end else if (done_i) begin
      pend_q   <= PEND_NONE;
      unlock_q <= 1'b0;
    end else if (arm_i) begin
      pend_q   <= PEND_SET;
      unlock_q <= 1'b1;
    end else if (disarm_i) begin
      pend_q   <= PEND_CLR;
      unlock_q <= 1'b1;
    end
  end

  assign prot_o      = prot_q;
  assign commit_ok_o = !prot_q || unlock_q;
endmodule

// File: rtl/cmdseq_guard.sv
`timescale 1ns/1ps
module cmdseq_guard
  import cmdseq_guard_pkg::*;
#(
  parameter int AW      = ADDR_W,
  parameter int DW      = DATA_W,
  parameter int BLC_CYC = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          prot_rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          prog_done_i,
  output logic          prot_o,
  output logic          commit_ok_o,
  output logic          cmd_byte_o
);
  phase_e ph;
  logic   take;
  logic   arm;
  logic   disarm;

  cmdseq_load_track #(.BLC_CYC(BLC_CYC)) u_load (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .done_i  (prog_done_i),
    .phase_o (ph),
    .take_o  (take)
  );

  cmdseq_matcher #(.AW(AW), .DW(DW)) u_match (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (prog_done_i),
    .take_i    (take),
    .addr_i    (addr_i),
    .data_i    (data_i),
    .hit_o     (cmd_byte_o),
    .arm_o     (arm),
    .disarm_o  (disarm)
  );

  cmdseq_prot_state u_prot (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .prot_rst_ni (prot_rst_ni),
    .done_i      (prog_done_i),
    .arm_i       (arm),
    .disarm_i    (disarm),
    .prot_o      (prot_o),
    .commit_ok_o (commit_ok_o)
  );
endmodule

// File: rtl/cmdseq_guard_chk.sv
`timescale 1ns/1ps
module cmdseq_guard_chk
  import cmdseq_guard_pkg::*;
(
  input logic   clk_i,
  input logic   rst_ni,
  input logic   prot_rst_ni,
  input logic   wr_i,
  input logic   prog_done_i,
  input phase_e phase_i,
  input logic   prot_i,
  input logic   commit_ok_i,
  input logic   cmd_byte_i
);
  p_cmd_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_byte_i |-> wr_i);

  p_prot_at_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || !prot_rst_ni)
    !$stable(prot_i) |-> $past(prog_done_i));

  p_open_unprot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni || !prot_rst_ni)
    !prot_i |-> commit_ok_i);

  p_prog_deaf_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_PROG && wr_i) |-> !cmd_byte_i);

  p_unlock_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni || !prot_rst_ni)
    prog_done_i |=> (commit_ok_i == !prot_i));
endmodule

bind cmdseq_guard cmdseq_guard_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .prot_rst_ni (prot_rst_ni),
  .wr_i        (wr_i),
  .prog_done_i (prog_done_i),
  .phase_i     (ph),
  .prot_i      (prot_o),
  .commit_ok_i (commit_ok_o),
  .cmd_byte_i  (cmd_byte_o)
);

// File: tb/sim_cmdseq_guard.sv
`timescale 1ns/1ps
module sim_cmdseq_guard;
  localparam int BLC = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prst_n = 1'b0;
  logic        wr = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  data = '0;
  logic        pd = 1'b0;
  logic        prot, cok, cmd;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2 clk = ~clk;

  cmdseq_guard #(.BLC_CYC(BLC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .prot_rst_ni(prst_n), .wr_i(wr),
    .addr_i(addr), .data_i(data), .prog_done_i(pd),
    .prot_o(prot), .commit_ok_o(cok), .cmd_byte_o(cmd)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(logic [14:0] a, logic [7:0] d, int exp_cmd, string tag);
    @(negedge clk);
    wr = 1'b1; addr = a; data = d;
    #1 chk(tag, int'(cmd), exp_cmd);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic close_load();
    repeat (BLC + 8) @(negedge clk);
  endtask

  task automatic done_pulse();
    @(negedge clk); pd = 1'b1;
    @(negedge clk); pd = 1'b0;
  endtask

  task automatic arm_seq(int exp, string tag);
    put(15'h5555, 8'hAA, exp, tag);
    put(15'h2AAA, 8'h55, exp, tag);
    put(15'h5555, 8'hA0, exp, tag);
  endtask

  task automatic t_reset();
    chk("R1 prot", int'(prot), 0);
    chk("R1 commit", int'(cok), 1);
    chk("R1 cmd", int'(cmd), 0);
  endtask

  task automatic t_arm_with_data();
    arm_seq(1, "R2 arm byte");
    put(15'h0100, 8'hAA, 0, "R2 data after arm");
    close_load();
    chk("R3 prot before done", int'(prot), 0);
    chk("R5 commit unprotected", int'(cok), 1);
    done_pulse();
    chk("R3 prot after done", int'(prot), 1);
    chk("R10 commit after done", int'(cok), 0);
  endtask

  task automatic t_plain_locked();
    put(15'h1234, 8'h5A, 0, "R5 plain byte");
    chk("R5 commit locked", int'(cok), 0);
    close_load();
    done_pulse();
    chk("R5 prot kept", int'(prot), 1);
  endtask

  task automatic t_unlocked_write();
    arm_seq(1, "R6 unlock byte");
    put(15'h4000, 8'h11, 0, "R6 data");
    chk("R6 commit unlocked", int'(cok), 1);
    close_load();
    done_pulse();
    chk("R6 prot kept", int'(prot), 1);
    chk("R10 unlock dropped", int'(cok), 0);
  endtask

  task automatic t_soft_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 prot in reset", int'(prot), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 prot after reset", int'(prot), 1);
  endtask

  task automatic t_closed_window();
    put(15'h0033, 8'h77, 0, "R8 opener");
    close_load();
    arm_seq(0, "R8 ignored key");
    chk("R8 no unlock", int'(cok), 0);
    done_pulse();
    chk("R8 prot kept", int'(prot), 1);
    chk("R8 commit after", int'(cok), 0);
    put(15'h5555, 8'hAA, 1, "R8 key start");
    close_load();
    put(15'h2AAA, 8'h55, 0, "R8 key after gap");
    put(15'h5555, 8'hA0, 0, "R8 key after gap");
    chk("R8 gap commit", int'(cok), 0);
    done_pulse();
  endtask

  task automatic t_mismatch();
    put(15'h5555, 8'hAA, 1, "R7 prefix");
    put(15'h2AAA, 8'h55, 1, "R7 prefix");
    put(15'h5555, 8'h80, 1, "R7 prefix");
    put(15'h5555, 8'h12, 0, "R7 wrong data");
    put(15'h5555, 8'hAA, 0, "R7 later key");
    chk("R7 commit", int'(cok), 0);
    close_load();
    done_pulse();
    chk("R7 prot kept", int'(prot), 1);
  endtask

  task automatic t_disarm();
    put(15'h5555, 8'hAA, 1, "R4 key");
    put(15'h2AAA, 8'h55, 1, "R4 key");
    put(15'h5555, 8'h80, 1, "R4 key");
    put(15'h5555, 8'hAA, 1, "R4 key");
    put(15'h2AAA, 8'h55, 1, "R4 key");
    put(15'h5555, 8'h20, 1, "R4 key");
    close_load();
    chk("R4 prot before done", int'(prot), 1);
    done_pulse();
    chk("R4 prot cleared", int'(prot), 0);
    chk("R4 commit", int'(cok), 1);
  endtask

  task automatic t_wrong_addr();
    put(15'h5554, 8'hAA, 0, "R7 wrong addr");
    put(15'h2AAA, 8'h55, 0, "R7 after miss");
    close_load();
    done_pulse();
    chk("R7 prot", int'(prot), 0);
  endtask

  task automatic t_arm_only_and_clear();
    arm_seq(1, "R3 bare arm");
    close_load();
    done_pulse();
    chk("R3 bare arm prot", int'(prot), 1);
    @(negedge clk); prst_n = 1'b0;
    #1 chk("R1 factory clear", int'(prot), 0);
    @(negedge clk); prst_n = 1'b1;
    chk("R1 commit after clear", int'(cok), 1);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; prst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_arm_with_data();
    t_plain_locked();
    t_unlocked_write();
    t_soft_reset();
    t_closed_window();
    t_mismatch();
    t_disarm();
    t_wrong_addr();
    t_arm_only_and_clear();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule